// File: doc/BRIEF.md
# Counter Overflow Interrupt Aggregator

This block sits at the front of a programmable counter array. It holds a free-running 16-bit counter. The counter advances on a clock-enable input while a run input is high. Two wrap detectors watch the counter. One reports a wrap of the full counter width. The other reports a wrap of the low 8, 9, 10 or 11 bits, and a 2-bit select picks that width. All modules that generate waveforms of 8 to 11 bits share this one select, so only one cycle length is in force at any time.

Eight event sources feed a bank of sticky flags: the two wrap detectors and six single-cycle event pulses, one from each capture/compare channel. A flag latches whenever its event occurs, even when its enable is clear. Software clears flags through a write port: a 0 in a bit position clears that flag, and a 1 leaves it alone. Each flag is ANDed with its own enable bit. The OR of those eight terms is gated by two global enables, and the result is registered to form a single interrupt request.

Top module: `ctr_irq_hub`

## Requirements
- R1: A synchronous active-high reset clears the counter, all eight flags and the interrupt request on the next clock edge.
- R2: The counter adds one, modulo 2^16, on each edge where run and tick_en are both 1. On every other edge it keeps its value.
- R3: Flag bit 7 (full wrap) sets on the edge where the counter advances from 16'hFFFF to 16'h0000.
- R4: Flag bit 6 (intermediate wrap) sets on the edge where the low N counter bits advance from all ones to zero. N is 8 + wsel: 2'b00 gives 8, 2'b01 gives 9, 2'b10 gives 10 and 2'b11 gives 11. A wrap of a narrower bit group does not set it.
- R5: Flag bit k, for k = 0 to 5, sets on the edge that samples chan_evt[k] high.
- R6: Every flag sets on its event whatever the value of its bit in ien.
- R7: Flags are sticky. An edge with wr_en high clears each flag whose wr_data bit is 0 and leaves unchanged each flag whose wr_data bit is 1.
- R8: When an event and a clearing write hit the same flag on the same edge, the flag ends up set.
- R9: irq equals the registered value of gie_a AND gie_b AND the OR over all bits of (flags AND ien). It therefore follows a flag change one cycle later.
- R10: irq is 0 on the edge after any cycle in which gie_a or gie_b is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Counter run control |
| tick_en | input | 1 | Counter clock enable |
| wsel | input | 2 | Intermediate wrap width select (8 + wsel bits) |
| chan_evt | input | 6 | Single-cycle channel event pulses |
| wr_en | input | 1 | Flag write strobe |
| wr_data | input | 8 | Flag write data; a 0 bit clears the flag |
| ien | input | 8 | Per-flag interrupt enables, same layout as flags |
| gie_a | input | 1 | First global interrupt enable |
| gie_b | input | 1 | Second global interrupt enable |
| count | output | 16 | Current counter value |
| flags | output | 8 | Flag bits: [5:0] channels, [6] intermediate wrap, [7] full wrap |
| irq | output | 1 | Registered interrupt request |

## Verification
The properties take for granted that reset is applied before the first useful edge. They also assume every input changes away from the active edge and that each channel event is a single-cycle pulse. The width select is treated as quasi-static: the stimulus changes wsel only while tick_en is low, so no wrap is detected against a width that changes mid-count. The bench writes flags only while the counter is halted, with one exception: it deliberately overlaps a channel pulse with a clearing write. That overlap lets the set-versus-clear ordering be seen on the ports.

// File: rtl/ctr_irq_pkg.sv
package ctr_irq_pkg;
  localparam int unsigned SEL_W = 2;

  function automatic int unsigned flag_total(input int unsigned n_chan);
    return n_chan + 2;
  endfunction
endpackage

// File: rtl/ctr_irq_counter.sv
module ctr_irq_counter #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned MIN_IW = 8,
  parameter int unsigned SEL_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick_en,
  input  logic [SEL_W-1:0] wsel,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_full_o,
  output logic             wrap_mid_o
);
  localparam int unsigned N_WID = 1 << SEL_W;
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;
  logic             adv;
  logic [N_WID-1:0] low_ones;

  assign adv = run & tick_en;

  generate
    for (genvar g = 0; g < N_WID; g++) begin : g_mid
      assign low_ones[g] = &cnt_q[MIN_IW+g-1:0];
    end
  endgenerate

  always_comb begin
    wrap_full_o = adv & (&cnt_q);
    wrap_mid_o  = adv & low_ones[wsel];
  end

  always_ff @(posedge clk) begin
    if (rst)      cnt_q <= '0;
    else if (adv) cnt_q <= cnt_q + ONE;
  end

  assign cnt_o = cnt_q;

  // R2: advance by exactly one
  p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
    adv |=> cnt_q == $past(cnt_q) + ONE);

  // R2: hold when not advancing
  p_count_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(cnt_q));

  // R4: a full wrap is also a wrap of any low bit group
  p_full_implies_mid_r4: assert property (@(posedge clk) disable iff (rst)
    wrap_full_o |-> wrap_mid_o);
endmodule

// File: rtl/ctr_irq_flags.sv
module ctr_irq_flags #(
  parameter int unsigned NF = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NF-1:0] set_i,
  input  logic          wr_en,
  input  logic [NF-1:0] wr_data,
  output logic [NF-1:0] flags_o
);
  logic [NF-1:0] flag_q;
  logic [NF-1:0] clr;

  assign clr = wr_en ? ~wr_data : '0;

  generate
    for (genvar i = 0; i < NF; i++) begin : g_flag
      always_ff @(posedge clk) begin
        if (rst)         flag_q[i] <= 1'b0;
        else if (set_i[i]) flag_q[i] <= 1'b1;
        else if (clr[i]) flag_q[i] <= 1'b0;
      end
    end
  endgenerate

  assign flags_o = flag_q;

  // R6: any event latches regardless of enables
  p_event_latches_r6: assert property (@(posedge clk) disable iff (rst)
    (|set_i) |=> ((flag_q & $past(set_i)) == $past(set_i)));

  // R7: flags not targeted by a clear stay set
  p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flag_q & $past(flag_q & ~clr)) == $past(flag_q & ~clr)));

  // R8: set beats a simultaneous clear
  p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (|(set_i & clr)) |=> ((flag_q & $past(set_i & clr)) == $past(set_i & clr)));
endmodule

// File: rtl/ctr_irq_req.sv
module ctr_irq_req #(
  parameter int unsigned NF = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NF-1:0] flags_i,
  input  logic [NF-1:0] ien,
  input  logic          gie_a,
  input  logic          gie_b,
  output logic          irq_o
);
  logic irq_q;
  logic any_src;

  assign any_src = |(flags_i & ien);

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= gie_a & gie_b & any_src;
  end

  assign irq_o = irq_q;

  // R10: either global enable low forces the request low
  p_global_gate_r10: assert property (@(posedge clk) disable iff (rst)
    !(gie_a && gie_b) |=> !irq_q);

  // R9: an enabled pending flag raises the request one cycle later
  p_request_follows_r9: assert property (@(posedge clk) disable iff (rst)
    (gie_a && gie_b && any_src) |=> irq_q);
endmodule

// File: rtl/ctr_irq_hub.sv
module ctr_irq_hub
  import ctr_irq_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned N_CHAN = 6,
  parameter int unsigned MIN_IW = 8
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              run,
  input  logic                              tick_en,
  input  logic [1:0]                        wsel,
  input  logic [N_CHAN-1:0]                 chan_evt,
  input  logic                              wr_en,
  input  logic [flag_total(N_CHAN)-1:0]     wr_data,
  input  logic [flag_total(N_CHAN)-1:0]     ien,
  input  logic                              gie_a,
  input  logic                              gie_b,
  output logic [CNT_W-1:0]                  count,
  output logic [flag_total(N_CHAN)-1:0]     flags,
  output logic                              irq
);
  localparam int unsigned NF       = flag_total(N_CHAN);
  localparam int unsigned MID_BIT  = N_CHAN;
  localparam int unsigned FULL_BIT = N_CHAN + 1;

  logic          wrap_full;
  logic          wrap_mid;
  logic [NF-1:0] set_vec;

  ctr_irq_counter #(.CNT_W(CNT_W), .MIN_IW(MIN_IW), .SEL_W(SEL_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .run        (run),
    .tick_en    (tick_en),
    .wsel       (wsel),
    .cnt_o      (count),
    .wrap_full_o(wrap_full),
    .wrap_mid_o (wrap_mid)
  );

  always_comb begin
    set_vec                = '0;
    set_vec[N_CHAN-1:0]    = chan_evt;
    set_vec[MID_BIT]       = wrap_mid;
    set_vec[FULL_BIT]      = wrap_full;
  end

  ctr_irq_flags #(.NF(NF)) u_flags (
    .clk    (clk),
    .rst    (rst),
    .set_i  (set_vec),
    .wr_en  (wr_en),
    .wr_data(wr_data),
    .flags_o(flags)
  );

  ctr_irq_req #(.NF(NF)) u_req (
    .clk    (clk),
    .rst    (rst),
    .flags_i(flags),
    .ien    (ien),
    .gie_a  (gie_a),
    .gie_b  (gie_b),
    .irq_o  (irq)
  );

  // R1: reset clears everything observable
  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (count == '0 && flags == '0 && !irq));

  // R3: counter wrap to zero marks the full-wrap flag
  p_main_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (run && tick_en && count == {CNT_W{1'b1}}) |=> (flags[FULL_BIT] && count == '0));

  // R5: channel pulses reach their flag bits
  p_chan_flag_r5: assert property (@(posedge clk) disable iff (rst)
    (|chan_evt) |=> ((flags[N_CHAN-1:0] & $past(chan_evt)) == $past(chan_evt)));
endmodule

// File: tb/ctr_irq_hub_tb_top.sv
`timescale 1ns/1ps
module ctr_irq_hub_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        run, tick_en, wr_en, gie_a, gie_b;
  logic [1:0]  wsel;
  logic [5:0]  chan_evt;
  logic [7:0]  wr_data, ien;
  logic [15:0] count;
  logic [7:0]  flags;
  logic        irq;

  typedef struct {
    string       tag;
    logic [7:0]  f;
    logic        i;
    logic [15:0] c;
  } item_t;

  item_t sb_q[$];
  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ctr_irq_hub dut_i (
    .clk(clk), .rst(rst), .run(run), .tick_en(tick_en), .wsel(wsel),
    .chan_evt(chan_evt), .wr_en(wr_en), .wr_data(wr_data), .ien(ien),
    .gie_a(gie_a), .gie_b(gie_b), .count(count), .flags(flags), .irq(irq)
  );

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(posedge clk);
    #1;
  endtask

  task automatic expect_item(input string tag, input logic [7:0] f,
                             input logic i, input logic [15:0] c);
    item_t it;
    it.tag = tag; it.f = f; it.i = i; it.c = c;
    sb_q.push_back(it);
  endtask

  task automatic wr_flags(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    cyc(1);
    wr_en = 1'b0; wr_data = 8'hFF;
  endtask

  // monitor: compare queued expectations away from the active edge
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_chk++;
      if (flags !== it.f || irq !== it.i || count !== it.c) begin
        n_err++;
        $display("FAIL %s: flags=%h irq=%b count=%h expected flags=%h irq=%b count=%h",
                 it.tag, flags, irq, count, it.f, it.i, it.c);
      end
    end
  end

  initial begin
    rst = 1'b1; run = 1'b0; tick_en = 1'b0; wr_en = 1'b0; wr_data = 8'hFF;
    gie_a = 1'b0; gie_b = 1'b0; wsel = 2'b01; chan_evt = '0; ien = '0;
    cyc(3);
    rst = 1'b0;
    expect_item("R1 reset state", 8'h00, 1'b0, 16'h0000);

    tick_en = 1'b1; cyc(5);
    expect_item("R2 hold with run low", 8'h00, 1'b0, 16'h0000);
    tick_en = 1'b0; run = 1'b1; cyc(5);
    expect_item("R2 hold with tick_en low", 8'h00, 1'b0, 16'h0000);

    tick_en = 1'b1; cyc(256);
    expect_item("R4 9-bit select ignores 8-bit wrap", 8'h00, 1'b0, 16'd256);
    cyc(256);
    expect_item("R4 9-bit wrap", 8'h40, 1'b0, 16'd512);
    tick_en = 1'b0;
    wr_flags(8'hBF);
    expect_item("R7 clear by zero bit", 8'h00, 1'b0, 16'd512);

    wsel = 2'b00; tick_en = 1'b1; cyc(256); tick_en = 1'b0;
    expect_item("R4 8-bit wrap", 8'h40, 1'b0, 16'd768);
    wr_flags(8'hBF);

    wsel = 2'b11; tick_en = 1'b1; cyc(1279); tick_en = 1'b0;
    expect_item("R4 11-bit not yet", 8'h00, 1'b0, 16'd2047);
    tick_en = 1'b1; cyc(1); tick_en = 1'b0;
    expect_item("R4 11-bit wrap", 8'h40, 1'b0, 16'd2048);
    wr_flags(8'hBF);

    wsel = 2'b10; tick_en = 1'b1; cyc(1024); tick_en = 1'b0;
    expect_item("R4 10-bit wrap", 8'h40, 1'b0, 16'd3072);
    wr_flags(8'hBF);

    gie_a = 1'b1; gie_b = 1'b1;
    chan_evt = 6'b000100; cyc(1); chan_evt = '0;
    expect_item("R5 R6 channel 2 latches while disabled", 8'h04, 1'b0, 16'd3072);
    cyc(1);
    expect_item("R6 disabled flag gives no request", 8'h04, 1'b0, 16'd3072);
    wr_flags(8'hFF);
    expect_item("R7 write of ones keeps flag", 8'h04, 1'b0, 16'd3072);

    ien = 8'h04; cyc(1);
    expect_item("R9 enabled flag raises irq", 8'h04, 1'b1, 16'd3072);
    gie_a = 1'b0; cyc(1);
    expect_item("R10 gie_a low masks", 8'h04, 1'b0, 16'd3072);
    gie_a = 1'b1; cyc(1);
    expect_item("R9 irq returns", 8'h04, 1'b1, 16'd3072);
    gie_b = 1'b0; cyc(1);
    expect_item("R10 gie_b low masks", 8'h04, 1'b0, 16'd3072);
    gie_b = 1'b1; cyc(1);
    wr_flags(8'hFB);
    expect_item("R9 irq lags flag clear", 8'h00, 1'b1, 16'd3072);
    cyc(1);
    expect_item("R9 irq drops after clear", 8'h00, 1'b0, 16'd3072);

    chan_evt = 6'b100000; wr_en = 1'b1; wr_data = 8'hDF;
    cyc(1);
    chan_evt = '0; wr_en = 1'b0; wr_data = 8'hFF;
    expect_item("R8 set beats clear", 8'h20, 1'b0, 16'd3072);
    chan_evt = 6'b001001; cyc(1); chan_evt = '0;
    expect_item("R5 channels 0 and 3", 8'h29, 1'b0, 16'd3072);
    wr_flags(8'h00);
    expect_item("R7 clear all", 8'h00, 1'b0, 16'd3072);

    ien = 8'h00; wsel = 2'b00;
    tick_en = 1'b1; cyc(65535 - 3072); tick_en = 1'b0;
    wr_flags(8'hBF);
    expect_item("R3 no full wrap before top", 8'h00, 1'b0, 16'hFFFF);
    ien = 8'h80;
    tick_en = 1'b1; cyc(1); tick_en = 1'b0;
    expect_item("R3 R4 full wrap sets both", 8'hC0, 1'b0, 16'h0000);
    cyc(1);
    expect_item("R9 full wrap request", 8'hC0, 1'b1, 16'h0000);

    tick_en = 1'b1; cyc(3); tick_en = 1'b0;
    rst = 1'b1; cyc(1); rst = 1'b0;
    expect_item("R1 reset clears state", 8'h00, 1'b0, 16'h0000);
    cyc(2);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog R1..: run did not end, actual=timeout expected=complete");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule